// File: doc/BRIEF.md
# Serial Display Register Write Master

This block writes 16-bit values into the indexed registers of an external display controller over a three-wire serial link: a clock, a data output and an active-low chip select. The host presents a register number and a 16-bit value with a one-cycle request strobe. The block then sends two separately framed messages. The first is an index message that selects the register. The second is a value message that carries the data.

Each message is 24 bits long: a one-byte command followed by a 16-bit payload, upper byte first. All timing is counted in units of `UNIT_CYCLES` system clock cycles. Each bit has a clock-low phase, a clock-high phase and a three-unit idle gap with clock and data high. An index-only request sends just the index message, so the controller is left pointing at a register and no data is written. `busy_o` covers the whole transaction, and `done_o` marks its end.

Top module: `serial_reg_wr`

## Requirements
- R1: While and after reset, with no request, csn_o, sclk_o and sdo_o are 1, and busy_o and done_o are 0.
- R2: Every framed message carries exactly 24 bits, most significant bit first: bits 23..16 are the command byte, bits 15..8 are the payload's upper byte and bits 7..0 are its lower byte. Each bit is sampled on the rising sclk_o edge.
- R3: A full write (idx_only_i=0) sends the frame {8'h70, idx_i} and then, in a new chip-select window, the frame {8'h72, val_i}.
- R4: An index-only request (idx_only_i=1) sends only the frame {8'h70, idx_i}.
- R5: Each bit drives sclk_o low for one unit, with sdo_o holding the bit value. sclk_o is then high for one unit with the same data. Next come three units with sclk_o and sdo_o both high, so sclk_o stays high for four units between bits. While csn_o is low and outside a bit's low and high phases, sdo_o is 1.
- R6: csn_o falls, the bus stays idle for SETUP_UNITS (default 10) units, and then sclk_o falls for the first time. sclk_o is never low while csn_o is high.
- R7: csn_o rises four units after the last rising sclk_o edge of a frame (one high unit plus the three-unit gap). In a full write, csn_o stays high for exactly two units between the two messages: one unit of trailing idle and one unit of leading idle.
- R8: A request in the idle state makes busy_o high from the next cycle until the transaction ends. A request made while busy_o is high is ignored: no extra frame is sent and the captured value does not change.
- R9: done_o is a one-cycle pulse, raised in the first cycle in which busy_o is low again after a transaction. There is exactly one pulse per accepted request.
- R10: After each message's chip select rises, the bus stays idle with csn_o, sclk_o and sdo_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken only when idle |
| idx_only_i | input | 1 | 1: send the index message only |
| idx_i | input | 16 | Register number |
| val_i | input | 16 | Value to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| sclk_o | output | 1 | Serial clock, idle high |
| sdo_o | output | 1 | Serial data out, idle high |
| csn_o | output | 1 | Chip select, active low |

## Verification
The assertions check these rules on every cycle:
- data is held stable while the clock is low (R5);
- the clock never pulses outside chip select (R6);
- the captured request is frozen while busy (R8);
- `done_o` is a single pulse that coincides with the fall of `busy_o` (R9);
- the bit counter and phase timer stay within range.

Only the bench's scenarios can show the rest: the content and order of the frames, the per-phase unit counts, the two-unit chip-select gap between messages, and that an ignored request produces no extra frame. The scoreboard covers these for full writes, index-only writes, all-ones and all-zeros payloads, and a request made during a transaction.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int FRAME_BITS = 24;
  localparam logic [7:0] CMD_INDEX = 8'h70;
  localparam logic [7:0] CMD_VALUE = 8'h72;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SETUP, ST_BLO, ST_BHI, ST_GAP, ST_TAIL
  } srw_state_e;
endpackage

// File: rtl/srw_unit_timer.sv
module srw_unit_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_LOAD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> len_i != '0); // R5
endmodule

// File: rtl/srw_shifter.sv
module srw_shifter #(
  parameter int NB = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NB-1:0] frame_i,
  input  logic          shift_i,
  output logic          msb_o,
  output logic          last_o
);
  localparam int CW = $clog2(NB);

  logic [NB-1:0] sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '1;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= frame_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[NB-2:0], 1'b1};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign msb_o  = sr_q[NB-1];
  assign last_o = (cnt_q == CW'(NB-1));

  AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> cnt_q < CW'(NB-1)); // R2
endmodule

// File: rtl/serial_reg_wr.sv
module serial_reg_wr
  import srw_pkg::*;
#(
  parameter int UNIT_CYCLES = 4,
  parameter int SETUP_UNITS = 10,
  parameter int GAP_UNITS   = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        idx_only_i,
  input  logic [15:0] idx_i,
  input  logic [15:0] val_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        sclk_o,
  output logic        sdo_o,
  output logic        csn_o
);
  localparam int MAX_UNITS = (SETUP_UNITS > GAP_UNITS) ? SETUP_UNITS : GAP_UNITS;
  localparam int TW        = $clog2(MAX_UNITS * UNIT_CYCLES + 1) + 1;
  localparam logic [TW-1:0] LEN_ONE   = TW'(UNIT_CYCLES);
  localparam logic [TW-1:0] LEN_SETUP = TW'(SETUP_UNITS * UNIT_CYCLES);
  localparam logic [TW-1:0] LEN_GAP   = TW'(GAP_UNITS * UNIT_CYCLES);

  srw_state_e state_q, state_d;
  logic [15:0] val_q;
  logic        idx_only_q, second_q;
  logic        done_q;
  logic        tmr_zero, tmr_load;
  logic [TW-1:0] tmr_len;
  logic        sh_load, sh_shift, sh_msb, sh_last;
  logic [FRAME_BITS-1:0] frame_d;
  logic        done_d, take_req, start_second;

  always_comb begin
    state_d      = state_q;
    sh_load      = 1'b0;
    sh_shift     = 1'b0;
    frame_d      = {CMD_INDEX, idx_i};
    done_d       = 1'b0;
    take_req     = 1'b0;
    start_second = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d  = ST_LEAD;
        sh_load  = 1'b1;
        take_req = 1'b1;
      end
      ST_LEAD:  if (tmr_zero) state_d = ST_SETUP;
      ST_SETUP: if (tmr_zero) state_d = ST_BLO;
      ST_BLO:   if (tmr_zero) state_d = ST_BHI;
      ST_BHI:   if (tmr_zero) state_d = ST_GAP;
      ST_GAP: if (tmr_zero) begin
        if (sh_last) state_d = ST_TAIL;
        else begin
          state_d  = ST_BLO;
          sh_shift = 1'b1;
        end
      end
      ST_TAIL: if (tmr_zero) begin
        if (!idx_only_q && !second_q) begin
          state_d      = ST_LEAD;
          sh_load      = 1'b1;
          frame_d      = {CMD_VALUE, val_q};
          start_second = 1'b1;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Every state change reloads the phase timer for the state being entered.
  assign tmr_load = (state_d != state_q) && (state_d != ST_IDLE);

  always_comb begin
    unique case (state_d)
      ST_SETUP: tmr_len = LEN_SETUP;
      ST_GAP:   tmr_len = LEN_GAP;
      default:  tmr_len = LEN_ONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      val_q      <= '0;
      idx_only_q <= 1'b0;
      second_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (take_req) begin
        val_q      <= val_i;
        idx_only_q <= idx_only_i;
        second_q   <= 1'b0;
      end else if (start_second) begin
        second_q <= 1'b1;
      end
    end
  end

  srw_unit_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (tmr_zero)
  );

  srw_shifter #(.NB(FRAME_BITS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .frame_i (frame_d),
    .shift_i (sh_shift),
    .msb_o   (sh_msb),
    .last_o  (sh_last)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign csn_o  = (state_q == ST_IDLE) || (state_q == ST_LEAD) || (state_q == ST_TAIL);
  assign sclk_o = (state_q != ST_BLO);
  assign sdo_o  = ((state_q == ST_BLO) || (state_q == ST_BHI)) ? sh_msb : 1'b1;

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_o |=> $stable(sdo_o)); // R5
  AST_CLK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_o |-> !csn_o); // R6
  AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_i |=> $stable(val_q) && $stable(idx_only_q)); // R8
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

// File: tb/tb_serial_reg_wr.sv
module tb_serial_reg_wr;
  localparam int U     = 2;
  localparam int SETUP = 10;
  localparam int LIMIT = 40000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, idx_only = 1'b0;
  logic [15:0] idx = '0, val = '0;
  logic busy, done, sclk, sdo, csn;

  int total = 0, bad = 0;
  int cyc = 0;
  int exp_done = 0, got_done = 0;
  logic [23:0] exp_q[$];

  always #4 clk = ~clk;

  serial_reg_wr #(.UNIT_CYCLES(U), .SETUP_UNITS(SETUP), .GAP_UNITS(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .idx_only_i(idx_only),
    .idx_i(idx), .val_i(val), .busy_o(busy), .done_o(done),
    .sclk_o(sclk), .sdo_o(sdo), .csn_o(csn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Monitor state
  logic p_csn = 1'b1, p_sclk = 1'b1, p_busy = 1'b0, p_done = 1'b0;
  int t_csfall = 0, t_csrise = 0, t_sfall = 0, t_srise = 0;
  int nbits = 0, msg_in_txn = 0;
  logic [23:0] word = '0;
  bit tim_err = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      if (p_csn && !csn) begin
        t_csfall = cyc; nbits = 0; tim_err = 0; word = '0;
        if (msg_in_txn == 1)
          chk(cyc - t_csrise == 2*U, "R7 cs gap between messages", cyc - t_csrise, 2*U);
      end
      if (p_sclk && !sclk) begin
        if (nbits == 0)
          chk(cyc - t_csfall == SETUP*U, "R6 cs setup", cyc - t_csfall, SETUP*U);
        else if (cyc - t_srise != 4*U) tim_err = 1;
        t_sfall = cyc;
      end
      if (!p_sclk && sclk) begin
        if (cyc - t_sfall != U) tim_err = 1;
        word = {word[22:0], sdo};
        nbits++;
        t_srise = cyc;
      end
      if (!csn && sclk && (nbits == 0 || cyc - t_srise >= U) && !(!p_sclk) && sdo !== 1'b1)
        tim_err = 1;
      if (csn && (!sclk || !sdo)) tim_err = 1;
      if (!p_csn && csn) begin
        t_csrise = cyc;
        msg_in_txn++;
        chk(nbits == 24, "R2 bit count", nbits, 24);
        chk(cyc - t_srise == 4*U, "R7 cs rise after last bit", cyc - t_srise, 4*U);
        chk(!tim_err, "R5 bit phase timing / idle data", tim_err, 0);
        if (exp_q.size() == 0) chk(0, "R3 unexpected frame", word, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(word == e, "R3 R4 frame content", word, e);
        end
      end
      if (done) begin
        got_done++;
        msg_in_txn = 0;
        chk(!busy && p_busy, "R9 done at busy fall", {busy, p_busy}, 1);
      end
      if (p_done) chk(!done, "R9 done single cycle", done, 0);
      if (p_busy && !busy) chk(done, "R9 busy fall with done", done, 1);
    end
    p_csn = csn; p_sclk = sclk; p_busy = busy; p_done = done;
  end

  task automatic send(input logic [15:0] r, input logic [15:0] v, input bit io, input bit poke);
    @(negedge clk);
    req = 1'b1; idx = r; val = v; idx_only = io;
    exp_q.push_back({8'h70, r});
    if (!io) exp_q.push_back({8'h72, v});
    exp_done++;
    @(negedge clk);
    req = 1'b0;
    chk(busy, "R8 busy after request", busy, 1);
    if (poke) begin
      repeat (60) @(negedge clk);
      req = 1'b1; idx = ~r; val = ~v; idx_only = 1'b0;
      @(negedge clk);
      req = 1'b0;
      repeat (300) @(negedge clk);
      req = 1'b1; idx = 16'h1234; val = 16'h5678; idx_only = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(busy, "R8 still busy after ignored request", busy, 1);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(csn && sclk && sdo, "R10 bus idle after transaction", {csn, sclk, sdo}, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csn && sclk && sdo && !busy && !done, "R1 reset state",
        {csn, sclk, sdo, busy, done}, 5'b11100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(csn && sclk && sdo && !busy && !done, "R1 idle after reset",
        {csn, sclk, sdo, busy, done}, 5'b11100);
    send(16'h0010, 16'h4444, 1'b0, 1'b0);
    send(16'hA5C3, 16'h5A3C, 1'b0, 1'b0);
    send(16'h0022, 16'hDEAD, 1'b1, 1'b0); // R4 index only
    send(16'h0007, 16'h0077, 1'b0, 1'b1); // R8 requests during transaction
    send(16'hFFFF, 16'h0000, 1'b0, 1'b0);
    send(16'h0000, 16'hFFFF, 1'b0, 1'b0);
    send(16'h8001, 16'h0000, 1'b1, 1'b0); // R4
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
    chk(got_done == exp_done, "R9 done count", got_done, exp_done);
    chk(!busy && csn, "R10 final idle", {busy, csn}, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule